// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A table base register gives the location of the first-level table. A translation request is taken only while the walker is idle. The walker then reads the first-level descriptor through a single-outstanding memory read port. The descriptor names either a coarse second-level table, a fine second-level table, or nothing usable. For a usable descriptor the walker forms the second-level address, reads that entry, and decodes it as a 64KB, 4KB or 1KB page, or as an empty entry.

The result appears for exactly one cycle. It carries the physical address, the two cache/buffer attribute bits, the 4-bit domain number, the raw access permission field, a fault flag, the level at which the fault arose, and a size code. The block does no permission checking and keeps no translation cache. Because page offset bits overlap the table index, software that builds the tables must repeat a large or small page entry as many times as the overlap requires.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `mem_req` and `done_valid` are 0.
- R2: A write to the table base register keeps only bits 31:14 of `base_wdata`, and bits 13:0 of the base read as zero.
- R3: The first memory read of a walk has address {base[31:14], va[31:20], 2'b00}, and `mem_req` is a one-cycle pulse for each read.
- R4: A first-level descriptor with bits[1:0] equal to 00 or 10 ends the walk with `done_fault`=1 and `done_level`=0, after exactly one memory read. On such a fault the address, attribute, domain, permission and size outputs are all zero.
- R5: A first-level descriptor with bits[1:0]=01 (coarse) leads to a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits[1:0]=11 (fine) leads to a second read at {desc[31:12], va[19:10], 2'b00}.
- R7: `done_domain` equals bits[8:5] of the first-level descriptor on every walk that reaches the second level, whether or not that walk faults.
- R8: A second-level entry with bits[1:0]=01 gives size code 01, PA = {desc[31:16], va[15:0]}, `done_perm` = desc[11:4] and `done_cb` = desc[3:2].
- R9: A second-level entry with bits[1:0]=10 gives size code 10, PA = {desc[31:12], va[11:0]}, `done_perm` = desc[11:4] and `done_cb` = desc[3:2].
- R10: A second-level entry with bits[1:0]=11 that was reached through a fine table gives size code 11, PA = {desc[31:10], va[9:0]}, `done_perm` = {6'b0, desc[5:4]} and `done_cb` = desc[3:2].
- R11: A second-level entry with bits[1:0]=00, or with bits[1:0]=11 reached through a coarse table, gives `done_fault`=1, `done_level`=1 and size code 00. The PA, attribute and permission outputs are zero.
- R12: Only one walk is in flight. `req_valid` is ignored while `req_ready` is 0, and yields no read and no result.
- R13: `done_valid` is high for exactly one cycle per accepted request, and `req_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base; only bits 31:14 are kept |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | High while idle and able to accept a request |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor returned by memory |
| done_valid | output | 1 | Result valid, one cycle |
| done_fault | output | 1 | Translation fault |
| done_level | output | 1 | Fault level: 0 first, 1 second |
| done_size | output | 2 | 01 large, 10 small, 11 tiny, 00 on fault |
| done_pa | output | 32 | Physical address |
| done_cb | output | 2 | Cache/buffer attribute bits |
| done_domain | output | 4 | Domain number from the first-level descriptor |
| done_perm | output | 8 | Raw access permission field |

## Verification
The embedded assertions watch the handshake shape on every cycle. They check that each read request is a single-cycle pulse on a word-aligned address, that the latched address holds still during a walk, that a first-level fault goes straight to a level-0 result, and that a result is a one-cycle pulse followed by readiness. They also check that a fault-free result always carries a non-zero size code. Only the bench scenarios can show that the address arithmetic, the base masking, the per-size field extraction and the domain pass-through are right. The same holds for treating a tiny entry in a coarse table as a fault and for ignoring a request that arrives mid-walk. The bench shows these by comparing every read address and every result with values computed from the requirements.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   // walker sequencing
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_DONE = 2'd3
   } walk_st_e;

   // first-level descriptor type, bits[1:0]
   typedef enum logic [1:0] {
      L1_EMPTY  = 2'b00,
      L1_COARSE = 2'b01,
      L1_RSVD   = 2'b10,
      L1_FINE   = 2'b11
   } l1_kind_e;

   // second-level descriptor type, bits[1:0]; also the result size code
   typedef enum logic [1:0] {
      PG_NONE  = 2'b00,
      PG_LARGE = 2'b01,
      PG_SMALL = 2'b10,
      PG_TINY  = 2'b11
   } pg_kind_e;

   localparam int AP_W     = 2;          // one permission field
   localparam int AP_CNT   = 4;          // fields per large/small entry
   localparam int PERM_W   = AP_W * AP_CNT;
   localparam int PERM_LSB = 4;
   localparam int CB_LSB   = 2;
   localparam int DOM_W    = 4;
   localparam int DOM_LSB  = 5;

endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
   import pt_walker_pkg::*;
#(
   parameter int AW     = 32,
   parameter int L1_LSB = 20,   // lowest VA bit of the first-level index
   parameter int CT_LSB = 10,   // coarse table alignment
   parameter int FT_LSB = 12,   // fine table alignment
   parameter int SM_LSB = 12,   // 4KB page offset width
   parameter int TN_LSB = 10    // 1KB page offset width
) (
   input  logic [AW-1:0]    desc_i,
   input  logic [AW-1:0]    va_i,
   output logic             fault_o,
   output logic             fine_o,
   output logic [DOM_W-1:0] domain_o,
   output logic [AW-1:0]    l2_addr_o
);

   localparam int CW = (AW - CT_LSB) + (L1_LSB - SM_LSB) + 2;
   localparam int FW = (AW - FT_LSB) + (L1_LSB - TN_LSB) + 2;

   if (CW != AW) begin : g_bad_coarse
      $error("coarse second-level address does not fill AW bits");
   end
   if (FW != AW) begin : g_bad_fine
      $error("fine second-level address does not fill AW bits");
   end
   if (CT_LSB <= DOM_LSB + DOM_W) begin : g_bad_dom
      $error("domain field overlaps table base");
   end

   l1_kind_e        kind;
   logic [AW-1:0]   coarse_addr;
   logic [AW-1:0]   fine_addr;
   logic            unused_l1;

   assign kind        = l1_kind_e'(desc_i[1:0]);
   assign coarse_addr = {desc_i[AW-1:CT_LSB], va_i[L1_LSB-1:SM_LSB], 2'b00};
   assign fine_addr   = {desc_i[AW-1:FT_LSB], va_i[L1_LSB-1:TN_LSB], 2'b00};

   always_comb begin
      fault_o = 1'b0;
      fine_o  = 1'b0;
      unique case (kind)
         L1_EMPTY, L1_RSVD: fault_o = 1'b1;
         L1_FINE:           fine_o  = 1'b1;
         default:           fine_o  = 1'b0;
      endcase
   end

   assign domain_o  = desc_i[DOM_LSB+DOM_W-1:DOM_LSB];
   assign l2_addr_o = fine_o ? fine_addr : coarse_addr;

   assign unused_l1 = ^{desc_i[DOM_LSB-1:2], desc_i[CT_LSB-1:DOM_LSB+DOM_W],
                        va_i[AW-1:L1_LSB], va_i[TN_LSB-1:0]};

endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
   import pt_walker_pkg::*;
#(
   parameter int AW     = 32,
   parameter int LG_LSB = 16,   // 64KB page offset width
   parameter int SM_LSB = 12,   // 4KB page offset width
   parameter int TN_LSB = 10,   // 1KB page offset width
   parameter bit TINY_COARSE_FAULT = 1'b1
) (
   input  logic [AW-1:0]     desc_i,
   input  logic [AW-1:0]     va_i,
   input  logic              fine_i,
   output logic              fault_o,
   output logic [1:0]        size_o,
   output logic [AW-1:0]     pa_o,
   output logic [1:0]        cb_o,
   output logic [PERM_W-1:0] perm_o
);

   if (!(LG_LSB > SM_LSB && SM_LSB > TN_LSB && TN_LSB > PERM_LSB + AP_W)) begin : g_bad_pg
      $error("page offset widths must be strictly decreasing");
   end
   if (SM_LSB < PERM_LSB + PERM_W) begin : g_bad_perm
      $error("permission field overlaps small page base");
   end

   pg_kind_e kind;
   logic     tiny_bad;

   assign kind = pg_kind_e'(desc_i[1:0]);

   // policy for a 1KB entry met in a coarse table
   if (TINY_COARSE_FAULT) begin : g_tiny_fault
      assign tiny_bad = (kind == PG_TINY) && !fine_i;
   end else begin : g_tiny_pass
      logic unused_fine;
      assign unused_fine = fine_i;
      assign tiny_bad    = 1'b0;
   end

   assign fault_o = (kind == PG_NONE) || tiny_bad;

   always_comb begin
      size_o = fault_o ? PG_NONE : kind;
      cb_o   = fault_o ? 2'b00 : desc_i[CB_LSB+1:CB_LSB];
      pa_o   = '0;
      perm_o = '0;
      if (!fault_o) begin
         unique case (kind)
            PG_LARGE: begin
               pa_o   = {desc_i[AW-1:LG_LSB], va_i[LG_LSB-1:0]};
               perm_o = desc_i[PERM_LSB+PERM_W-1:PERM_LSB];
            end
            PG_SMALL: begin
               pa_o   = {desc_i[AW-1:SM_LSB], va_i[SM_LSB-1:0]};
               perm_o = desc_i[PERM_LSB+PERM_W-1:PERM_LSB];
            end
            PG_TINY: begin
               pa_o   = {desc_i[AW-1:TN_LSB], va_i[TN_LSB-1:0]};
               perm_o = {{(PERM_W-AP_W){1'b0}}, desc_i[PERM_LSB+AP_W-1:PERM_LSB]};
            end
            default: begin
               pa_o   = '0;
               perm_o = '0;
            end
         endcase
      end
   end

   logic unused_l2;
   assign unused_l2 = ^va_i[AW-1:LG_LSB];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int AW     = 32,
   parameter int TB_LSB = 14,   // first-level table alignment
   parameter int L1_LSB = 20,
   parameter int CT_LSB = 10,
   parameter int FT_LSB = 12,
   parameter int LG_LSB = 16,
   parameter int SM_LSB = 12,
   parameter int TN_LSB = 10,
   parameter bit TINY_COARSE_FAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [AW-1:0]     base_wdata,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_vaddr,
   output logic              req_ready,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [AW-1:0]     mem_rdata,
   output logic              done_valid,
   output logic              done_fault,
   output logic              done_level,
   output logic [1:0]        done_size,
   output logic [AW-1:0]     done_pa,
   output logic [1:0]        done_cb,
   output logic [DOM_W-1:0]  done_domain,
   output logic [PERM_W-1:0] done_perm
);

   localparam int TB_W = AW - TB_LSB;
   localparam int IX_W = AW - L1_LSB;

   if (TB_W + IX_W + 2 != AW) begin : g_bad_l1
      $error("first-level address does not fill AW bits");
   end

   walk_st_e          st;
   logic [AW-1:0]     va_q;
   logic [TB_W-1:0]   tbase_q;
   logic              issued_q;
   logic [AW-1:0]     l2_addr_q;
   logic              fine_q;
   logic [DOM_W-1:0]  dom_q;

   logic              l1_fault, l1_fine;
   logic [DOM_W-1:0]  l1_dom;
   logic [AW-1:0]     l1_l2addr;
   logic              l2_fault;
   logic [1:0]        l2_size, l2_cb;
   logic [AW-1:0]     l2_pa;
   logic [PERM_W-1:0] l2_perm;

   pt_l1_decode #(
      .AW(AW), .L1_LSB(L1_LSB), .CT_LSB(CT_LSB), .FT_LSB(FT_LSB),
      .SM_LSB(SM_LSB), .TN_LSB(TN_LSB)
   ) u_l1 (
      .desc_i(mem_rdata), .va_i(va_q),
      .fault_o(l1_fault), .fine_o(l1_fine),
      .domain_o(l1_dom), .l2_addr_o(l1_l2addr)
   );

   pt_l2_decode #(
      .AW(AW), .LG_LSB(LG_LSB), .SM_LSB(SM_LSB), .TN_LSB(TN_LSB),
      .TINY_COARSE_FAULT(TINY_COARSE_FAULT)
   ) u_l2 (
      .desc_i(mem_rdata), .va_i(va_q), .fine_i(fine_q),
      .fault_o(l2_fault), .size_o(l2_size), .pa_o(l2_pa),
      .cb_o(l2_cb), .perm_o(l2_perm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         va_q        <= '0;
         tbase_q     <= '0;
         issued_q    <= 1'b0;
         l2_addr_q   <= '0;
         fine_q      <= 1'b0;
         dom_q       <= '0;
         done_fault  <= 1'b0;
         done_level  <= 1'b0;
         done_size   <= PG_NONE;
         done_pa     <= '0;
         done_cb     <= '0;
         done_domain <= '0;
         done_perm   <= '0;
      end else begin
         if (base_we) tbase_q <= base_wdata[AW-1:TB_LSB];
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_vaddr;
                  issued_q <= 1'b0;
                  st       <= ST_L1;
               end
            end
            ST_L1: begin
               issued_q <= 1'b1;
               if (mem_rvalid && issued_q) begin
                  if (l1_fault) begin
                     done_fault  <= 1'b1;
                     done_level  <= 1'b0;
                     done_size   <= PG_NONE;
                     done_pa     <= '0;
                     done_cb     <= '0;
                     done_domain <= '0;
                     done_perm   <= '0;
                     st          <= ST_DONE;
                  end else begin
                     l2_addr_q <= l1_l2addr;
                     fine_q    <= l1_fine;
                     dom_q     <= l1_dom;
                     issued_q  <= 1'b0;
                     st        <= ST_L2;
                  end
               end
            end
            ST_L2: begin
               issued_q <= 1'b1;
               if (mem_rvalid && issued_q) begin
                  done_fault  <= l2_fault;
                  done_level  <= l2_fault;
                  done_size   <= l2_size;
                  done_pa     <= l2_pa;
                  done_cb     <= l2_cb;
                  done_domain <= dom_q;
                  done_perm   <= l2_perm;
                  st          <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == ST_IDLE);
   assign done_valid = (st == ST_DONE);
   assign mem_req    = ((st == ST_L1) || (st == ST_L2)) && !issued_q;
   assign mem_addr   = (st == ST_L2) ? l2_addr_q
                                     : {tbase_q, va_q[AW-1:L1_LSB], 2'b00};

   logic unused_base;
   assign unused_base = ^base_wdata[TB_LSB-1:0];

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R3
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !done_valid) |=> $stable(va_q));

   // R4
   sect_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_L1 && mem_rvalid && issued_q && l1_fault)
      |=> (done_valid && done_fault && !done_level && !mem_req));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   // R11
   ok_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault) |-> (done_size != 2'b00));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid, done_fault, done_level;
   logic [1:0]  done_size, done_cb;
   logic [31:0] done_pa;
   logic [3:0]  done_domain;
   logic [7:0]  done_perm;

   always #4 clk = ~clk;   // 125 MHz

   pt_walker u_pt_walker (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done_valid(done_valid), .done_fault(done_fault),
      .done_level(done_level), .done_size(done_size), .done_pa(done_pa),
      .done_cb(done_cb), .done_domain(done_domain), .done_perm(done_perm)
   );

   typedef struct {
      logic [31:0] pa;
      logic [1:0]  cb;
      logic [3:0]  dom;
      logic [7:0]  perm;
      logic        fault;
      logic        lvl;
      logic [1:0]  size;
      int          nrd;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] base_model = '0;
   logic [31:0] exp_a1, exp_a2, mem_d1, mem_d2;
   int          rd_cnt = 0;
   int          lat_cnt = 0;
   logic        ready_probe = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // memory responder and result monitor share one negedge process
   always @(negedge clk) begin
      if (mem_rvalid) mem_rvalid <= 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= (rd_cnt == 1) ? mem_d1 : mem_d2;
         end
      end
      if (mem_req) begin
         rd_cnt <= rd_cnt + 1;
         lat_cnt <= 2 + (rd_cnt % 2);
         if (rd_cnt == 0)
            check(mem_addr == exp_a1, "R3 first-level address", 128'(mem_addr), 128'(exp_a1));
         else
            check(mem_addr == exp_a2, "R5/R6 second-level address (R5 R6)",
                  128'(mem_addr), 128'(exp_a2));
      end
      if (ready_probe) begin
         ready_probe <= 1'b0;
         check(req_ready && !done_valid, "R13 ready after result",
               128'({req_ready, done_valid}), 128'(2'b10));
      end
      if (done_valid) begin
         ready_probe <= 1'b1;
         if (sb_q.size() == 0) begin
            check(1'b0, "R12 unexpected result", 128'(done_pa), 128'(0));
         end else begin
            exp_t e;
            logic [52:0] act, exv;
            e   = sb_q.pop_front();
            act = {done_pa, done_cb, done_domain, done_perm, done_fault, done_level, done_size, 3'(rd_cnt)};
            exv = {e.pa, e.cb, e.dom, e.perm, e.fault, e.lvl, e.size, 3'(e.nrd)};
            check(act == exv, e.tag, 128'(act), 128'(exv));
         end
         rd_cnt <= 0;
      end
   end

   // expected result from the requirements
   task automatic walk(input logic [31:0] va, input logic [31:0] d1,
                       input logic [31:0] d2, input string tag, input bit poke_busy);
      exp_t e;
      bit   fine;
      e.tag = tag; e.pa = '0; e.cb = '0; e.dom = '0; e.perm = '0;
      e.fault = 1'b0; e.lvl = 1'b0; e.size = 2'b00;
      exp_a1 = {base_model[31:14], va[31:20], 2'b00};
      mem_d1 = d1; mem_d2 = d2;
      if (d1[1:0] == 2'b00 || d1[1:0] == 2'b10) begin       // R4
         e.fault = 1'b1; e.nrd = 1; exp_a2 = 32'hFFFF_FFFF;
      end else begin
         fine   = (d1[1:0] == 2'b11);
         exp_a2 = fine ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
         e.dom  = d1[8:5];                                   // R7
         e.nrd  = 2;
         if (d2[1:0] == 2'b00 || (d2[1:0] == 2'b11 && !fine)) begin   // R11
            e.fault = 1'b1; e.lvl = 1'b1;
         end else begin
            e.size = d2[1:0];
            e.cb   = d2[3:2];
            case (d2[1:0])
               2'b01:   begin e.pa = {d2[31:16], va[15:0]}; e.perm = d2[11:4]; end  // R8
               2'b10:   begin e.pa = {d2[31:12], va[11:0]}; e.perm = d2[11:4]; end  // R9
               default: begin e.pa = {d2[31:10], va[9:0]};  e.perm = {6'b0, d2[5:4]}; end // R10
            endcase
         end
      end
      sb_q.push_back(e);
      req_vaddr = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke_busy) begin
         @(negedge clk);
         req_vaddr = ~va;
         req_valid = 1'b1;
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready && !mem_req && !done_valid, "R1 reset state",
            128'({req_ready, mem_req, done_valid}), 128'(3'b100));
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !mem_req && !done_valid, "R1 idle after reset",
            128'({req_ready, mem_req, done_valid}), 128'(3'b100));

      // R2 base write keeps bits 31:14 only
      base_wdata = 32'h1234_5FFF; base_we = 1'b1;
      @(negedge clk);
      base_we = 1'b0;
      base_model = 32'h1234_4000;

      walk(32'hABCD_1234, 32'h0030_04A1, 32'h8765_0A5D, "R2 R5 R8 coarse large", 1'b0);
      walk(32'h0120_F0FF, 32'h0030_04A1, 32'h1234_53C6, "R5 R9 coarse small", 1'b0);
      walk(32'hFFF5_6789, 32'h0055_51E3, 32'hFFFF_FC2B, "R6 R10 fine tiny", 1'b0);
      walk(32'h7777_7777, 32'h0055_51E3, 32'hCAFE_0F31, "R6 R8 fine large", 1'b0);
      walk(32'h0000_0C04, 32'h0055_51E3, 32'hBEEF_1ABA, "R6 R9 fine small", 1'b0);
      walk(32'h4444_0000, 32'hDEAD_BEEC, 32'h0, "R4 first-level empty", 1'b0);
      walk(32'h5555_0000, 32'hDEAD_BEEE, 32'h0, "R4 first-level type 10", 1'b0);
      walk(32'h6666_1000, 32'h0030_04E1, 32'hFFFF_FFFC, "R11 second-level empty R7", 1'b0);
      walk(32'h6666_2000, 32'h0030_04E1, 32'h1234_567B, "R11 tiny in coarse", 1'b0);
      walk(32'h1357_9BDF, 32'h00AB_C021, 32'h2468_ACE6, "R12 busy request ignored", 1'b1);

      base_wdata = 32'hFFFF_FFFF; base_we = 1'b1;
      @(negedge clk);
      base_we = 1'b0;
      base_model = 32'hFFFF_C000;
      for (int i = 0; i < 24; i++) begin
         logic [31:0] va, d1, d2;
         va = 32'h9E37_79B9 * (i + 1);
         d1 = ((32'h3C6E_F372 * (i + 7)) & 32'hFFFF_FFFC) | 32'(i % 4);
         d2 = ((32'hDEAD_BEEF ^ (32'h0101_0101 * i)) & 32'hFFFF_FFFC) | 32'((i / 4) % 4);
         walk(va, d1, d2, "R7 mixed walk", 1'b0);
      end

      repeat (10) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule